// File: doc/BRIEF.md
# Character Row Pixel Serializer

This block turns a stream of character codes into the serial pixel stream of a text display. A scanline begins with a start pulse that carries the raster line inside the current text row. The block then takes one character code per cell and forms a glyph memory address from the code and its own scanline counter. It loads the returned 14-bit glyph slice into a shift register and sends it out one pixel per clock. In the cursor column the low eight bits of the slice are flipped first.

Character codes with two particular bits set are attribute markers. Their low nibble becomes the row attribute, which is shown on `attr_out`. A second register, the screen attribute, carries the attribute from one text row to the next. At the start of a scanline on raster line zero it takes a copy of the row attribute. On any other raster line the row attribute is reloaded from it. Vertical sync clears the screen attribute. Colour mapping and the use of the attribute on the pixels are left to later logic.

The control is a five-state machine. ST_IDLE waits for a scanline start; the transition T_BEGIN leads to ST_READY. ST_READY waits for the first code; T_ACCEPT leads to ST_FADDR, in which the address is on the glyph memory. T_READ leads to ST_FDATA, in which the slice is returned. T_LOAD leads to ST_SHIFT, which emits the 14 pixels. From ST_SHIFT, T_CHAIN stays in ST_SHIFT and loads the next cell when a code was accepted during the current cell. Otherwise T_END returns to ST_IDLE and advances the scanline counter.

Top module: `char_row_serializer`

## Requirements
- R1: Reset clears the scanline counter (`line_num`), the row attribute (`attr_out`), the screen attribute and `glyph_addr` to 0, and `pix_valid` to 0.
- R2: A code accepted at a clock edge puts `glyph_addr` = code*16 + (`line_num` mod 10) on the output from the next cycle. The code occupies bits 11:4 and the slot occupies bits 3:0.
- R3: The first pixel of a cell accepted in ST_READY appears on `pix_out` two cycles after the address, that is three edges after acceptance. It is followed by the other 13 pixels with `pix_valid` high, glyph bit 13 first and bit 0 last. The slice is the one the memory returns one cycle after the address.
- R4: A column counter is cleared at scanline start and counts accepted cells from 0. When the cell's column equals `cursor_col`, the emitted slice is the glyph with bits 7:0 inverted and bits 13:8 unchanged.
- R5: A code presented while pixel index 11 of the current cell is on the output is fetched so that its first pixel directly follows pixel 13, with no gap in `pix_valid`.
- R6: When pixel 13 of a cell goes out and no further code was accepted, `pix_valid` falls on the next edge and `line_num` advances by one. It wraps from 249 to 0, and the address slot follows `line_num` mod 10.
- R7: An accepted code whose bits 7 and 4 are both 1 sets `attr_out` to its bits 3:0 from the next cycle. Any other code leaves `attr_out` unchanged.
- R8: At an honoured scanline start with `raster_line` = 0, the screen attribute copies the row attribute. With any other raster line, the row attribute (`attr_out`) is reloaded from the screen attribute.
- R9: `vsync` clears the screen attribute to 0 and leaves `attr_out` unchanged.
- R10: `chr_valid` is ignored in ST_IDLE and in ST_SHIFT at every pixel index other than 11. `line_start` is ignored outside ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Scanline start pulse |
| raster_line | input | 4 | Raster line within the text row, sampled with `line_start` |
| vsync | input | 1 | Vertical sync, clears the screen attribute |
| chr_valid | input | 1 | Character code strobe |
| chr_code | input | 8 | Character code from display memory |
| cursor_col | input | 7 | Cursor column index |
| glyph_addr | output | 12 | Glyph memory address |
| glyph_data | input | 14 | Glyph slice, one cycle after the address |
| pix_out | output | 1 | Serial pixel |
| pix_valid | output | 1 | Pixel on `pix_out` is part of a cell |
| attr_out | output | 4 | Current row attribute |
| line_num | output | 8 | Scanline counter |

## Verification
The hardest situation to reach from the ports is the overlap of two cells. The next code has to be presented in exactly the one cycle where pixel index 11 is showing. That fetch then runs while pixels 12 and 13 of the previous cell are still being sent. The stimulus counts pixels as they appear and raises `chr_valid` on the twelfth pixel of each cell, so multi-cell scanlines run with no gap. In a separate scanline a marker code and a raster-zero scanline start are injected at pixel 2. Both must leave the pixels, the cell count and `attr_out` untouched. The counter wrap at 250 is reached by running a few hundred single-cell scanlines and checking the address slot on every one.

// File: rtl/crs_pkg.sv
package crs_pkg;

    // Control states of the serializer
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // between scanlines
        ST_READY = 3'd1,   // scanline open, first code awaited
        ST_FADDR = 3'd2,   // address on glyph memory
        ST_FDATA = 3'd3,   // glyph slice returned
        ST_SHIFT = 3'd4    // pixels of a cell going out
    } crs_state_e;

endpackage

// File: rtl/crs_fetch.sv
// Glyph address register and scanline counters.
module crs_fetch #(
    parameter int CODE_W   = 8,
    parameter int SLOT_W   = 4,
    parameter int GLY_ROWS = 10,
    parameter int LINES    = 250
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        accept,
    input  logic [CODE_W-1:0]           code,
    input  logic                        line_done,
    output logic [CODE_W+SLOT_W-1:0]    glyph_addr,
    output logic [$clog2(LINES)-1:0]    line_num
);

    localparam int                LN_W      = $clog2(LINES);
    localparam logic [LN_W-1:0]   LN_LAST   = LN_W'(LINES - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(GLY_ROWS - 1);

    logic [SLOT_W-1:0] slot;

    // Scanline counter and its modulo-GLY_ROWS companion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_num <= '0;
            slot     <= '0;
        end else if (line_done) begin
            if (line_num == LN_LAST) begin
                line_num <= '0;
                slot     <= '0;
            end else begin
                line_num <= line_num + 1'b1;
                slot     <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
            end
        end
    end

    // Address = code * 2**SLOT_W + slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            glyph_addr <= '0;
        else if (accept)
            glyph_addr <= {code, slot};
    end

endmodule

// File: rtl/crs_attr.sv
// Row and screen attribute registers.
module crs_attr #(
    parameter int ATTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_begin,
    input  logic              first_raster,
    input  logic              mark_set,
    input  logic [ATTR_W-1:0] mark_val,
    input  logic              vsync,
    output logic [ATTR_W-1:0] row_attr,
    output logic [ATTR_W-1:0] scr_attr
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            row_attr <= '0;
        else if (mark_set)
            row_attr <= mark_val;
        else if (line_begin && !first_raster)
            row_attr <= scr_attr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            scr_attr <= '0;
        else if (vsync)
            scr_attr <= '0;
        else if (line_begin && first_raster)
            scr_attr <= row_attr;
    end

endmodule

// File: rtl/crs_shifter.sv
// Cell shift register, most significant bit out first.
module crs_shifter #(
    parameter int CELL_W = 14,
    parameter int INV_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic                        invert,
    input  logic [CELL_W-1:0]           din,
    input  logic                        shift,
    output logic                        pix,
    output logic [$clog2(CELL_W)-1:0]   idx
);

    localparam logic [CELL_W-1:0] INV_MASK = {{(CELL_W-INV_W){1'b0}}, {INV_W{1'b1}}};
    localparam int                IDX_W    = $clog2(CELL_W);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(CELL_W - 1);

    logic [CELL_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            idx <= '0;
        end else if (load) begin
            sr  <= invert ? (din ^ INV_MASK) : din;
            idx <= '0;
        end else if (shift) begin
            sr  <= {sr[CELL_W-2:0], 1'b0};
            idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
        end
    end

    assign pix = sr[CELL_W-1];

endmodule

// File: rtl/char_row_serializer.sv
module char_row_serializer
    import crs_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int SLOT_W   = 4,
    parameter int GLY_ROWS = 10,
    parameter int LINES    = 250,
    parameter int CELL_W   = 14,
    parameter int INV_W    = 8,
    parameter int ATTR_W   = 4,
    parameter int MARK_BIT = 4,
    parameter int RA_W     = 4,
    parameter int COL_W    = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        line_start,
    input  logic [RA_W-1:0]             raster_line,
    input  logic                        vsync,
    input  logic                        chr_valid,
    input  logic [CODE_W-1:0]           chr_code,
    input  logic [COL_W-1:0]            cursor_col,
    output logic [CODE_W+SLOT_W-1:0]    glyph_addr,
    input  logic [CELL_W-1:0]           glyph_data,
    output logic                        pix_out,
    output logic                        pix_valid,
    output logic [ATTR_W-1:0]           attr_out,
    output logic [$clog2(LINES)-1:0]    line_num
);

    localparam int               IDX_W    = $clog2(CELL_W);
    localparam logic [IDX_W-1:0] ACC_IDX  = IDX_W'(CELL_W - 3);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_W - 1);

    crs_state_e        state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic [COL_W-1:0]  col;
    logic              cur_hit;
    logic              q_addr, q_data;
    logic              last_pix, accept, line_begin, load, line_done, mark_set;
    logic              sr_pix;
    logic [ATTR_W-1:0] row_attr, scr_attr;

    assign last_pix   = (state == ST_SHIFT) && (idx == LAST_IDX);
    assign accept     = chr_valid &&
                        ((state == ST_READY) || ((state == ST_SHIFT) && (idx == ACC_IDX)));
    assign line_begin = line_start && (state == ST_IDLE);
    assign load       = (state == ST_FDATA) || (last_pix && q_data);
    assign line_done  = last_pix && !q_data;
    assign mark_set   = accept && chr_code[CODE_W-1] && chr_code[MARK_BIT];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (line_start) state_nx = ST_READY;     // T_BEGIN
            ST_READY: if (chr_valid)  state_nx = ST_FADDR;     // T_ACCEPT
            ST_FADDR: state_nx = ST_FDATA;                     // T_READ
            ST_FDATA: state_nx = ST_SHIFT;                     // T_LOAD
            ST_SHIFT: if (last_pix && !q_data) state_nx = ST_IDLE; // T_END, else T_CHAIN
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Overlapped fetch tracking and cursor column
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= 1'b0;
            q_data  <= 1'b0;
            col     <= '0;
            cur_hit <= 1'b0;
        end else begin
            q_addr <= accept && (state == ST_SHIFT);
            q_data <= q_addr;
            if (line_begin)
                col <= '0;
            else if (accept)
                col <= col + 1'b1;
            if (accept)
                cur_hit <= (col == cursor_col);
        end
    end

    crs_fetch #(
        .CODE_W(CODE_W), .SLOT_W(SLOT_W), .GLY_ROWS(GLY_ROWS), .LINES(LINES)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .accept(accept), .code(chr_code),
        .line_done(line_done), .glyph_addr(glyph_addr), .line_num(line_num)
    );

    crs_attr #(.ATTR_W(ATTR_W)) u_attr (
        .clk(clk), .rst_n(rst_n), .line_begin(line_begin),
        .first_raster(raster_line == '0), .mark_set(mark_set),
        .mark_val(chr_code[ATTR_W-1:0]), .vsync(vsync),
        .row_attr(row_attr), .scr_attr(scr_attr)
    );

    crs_shifter #(.CELL_W(CELL_W), .INV_W(INV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .invert(cur_hit),
        .din(glyph_data), .shift(state == ST_SHIFT), .pix(sr_pix), .idx(idx)
    );

    // Outputs
    always_comb begin
        pix_valid = (state == ST_SHIFT);
        pix_out   = (state == ST_SHIFT) && sr_pix;
        attr_out  = row_attr;
    end

endmodule

// File: rtl/char_row_serializer_chk.sv
module char_row_serializer_chk
    import crs_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int SLOT_W = 4,
    parameter int LINES  = 250,
    parameter int ATTR_W = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        chr_valid,
    input logic [CODE_W-1:0]           chr_code,
    input logic                        vsync,
    input logic [CODE_W+SLOT_W-1:0]    glyph_addr,
    input logic                        pix_valid,
    input logic [ATTR_W-1:0]           attr_out,
    input logic [$clog2(LINES)-1:0]    line_num,
    input logic                        accept,
    input logic [ATTR_W-1:0]           scr_attr,
    input crs_state_e                  state
);

    assert_addr_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> glyph_addr[CODE_W+SLOT_W-1:SLOT_W] == $past(chr_code));

    assert_first_pixel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && state == ST_READY) |=> ##2 pix_valid);

    assert_marker_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && chr_code[CODE_W-1] && chr_code[4]) |=> attr_out == $past(chr_code[ATTR_W-1:0]));

    assert_line_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pix_valid) |-> line_num != $past(line_num));

    assert_line_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_num < ($clog2(LINES))'(LINES));

    assert_vsync_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> scr_attr == '0);

    assert_idle_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(glyph_addr));

endmodule

bind char_row_serializer char_row_serializer_chk #(
    .CODE_W(CODE_W), .SLOT_W(SLOT_W), .LINES(LINES), .ATTR_W(ATTR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_code(chr_code),
    .vsync(vsync), .glyph_addr(glyph_addr), .pix_valid(pix_valid),
    .attr_out(attr_out), .line_num(line_num), .accept(accept),
    .scr_attr(scr_attr), .state(state)
);

// File: tb/char_row_serializer_test.sv
`timescale 1ns/1ps
module char_row_serializer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [3:0]  raster_line = '0;
    logic        vsync = 1'b0;
    logic        chr_valid = 1'b0;
    logic [7:0]  chr_code = '0;
    logic [6:0]  cursor_col = '0;
    logic [11:0] glyph_addr;
    logic [13:0] glyph_q = '0;
    logic        pix_out, pix_valid;
    logic [3:0]  attr_out;
    logic [7:0]  line_num;

    int n_chk  = 0;
    int n_fail = 0;
    int m_ln   = 0;

    always #4 clk = ~clk;

    char_row_serializer uut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .raster_line(raster_line),
        .vsync(vsync), .chr_valid(chr_valid), .chr_code(chr_code), .cursor_col(cursor_col),
        .glyph_addr(glyph_addr), .glyph_data(glyph_q), .pix_out(pix_out),
        .pix_valid(pix_valid), .attr_out(attr_out), .line_num(line_num)
    );

    function automatic logic [13:0] gfun(input logic [11:0] a);
        int v;
        v = int'(a) * 173 + 91;
        return v[13:0] ^ 14'h2A5B;
    endfunction

    // Glyph memory model, one cycle read latency
    always @(posedge clk) glyph_q <= gfun(glyph_addr);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Stimulus: ra[39:36] cursor[35:32] cells[31:28] c0 c1 c2 expected attr[3:0]
    localparam int NV = 8;
    localparam logic [39:0] VEC [NV] = '{
        {4'd0, 4'd15, 4'd1, 8'h41, 8'h00, 8'h00, 4'h0},
        {4'd0, 4'd1,  4'd3, 8'h42, 8'h95, 8'h43, 4'h5},
        {4'd1, 4'd0,  4'd2, 8'h20, 8'h31, 8'h00, 4'h0},
        {4'd0, 4'd2,  4'd3, 8'h9A, 8'h7F, 8'h00, 4'hA},
        {4'd0, 4'd15, 4'd1, 8'h10, 8'h00, 8'h00, 4'hA},
        {4'd3, 4'd15, 4'd2, 8'h55, 8'h80, 8'h00, 4'hA},
        {4'd2, 4'd0,  4'd1, 8'hF3, 8'h00, 8'h00, 4'h3},
        {4'd5, 4'd15, 4'd1, 8'h44, 8'h00, 8'h00, 4'hA}
    };

    task automatic run_line(input logic [3:0] ra, input int cur, input int n,
                            input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] c2,
                            input bit poke, input logic [3:0] exp_attr);
        logic [7:0]  codes [3];
        logic [3:0]  slot;
        logic [13:0] word, expw;
        bit          gap;
        codes = '{c0, c1, c2};
        slot  = 4'(m_ln % 10);
        word  = '0;
        gap   = 1'b0;
        cursor_col = 7'(cur);
        @(negedge clk);
        line_start = 1'b1; raster_line = ra;
        @(negedge clk);
        line_start = 1'b0; chr_valid = 1'b1; chr_code = codes[0];
        @(negedge clk);
        chr_valid = 1'b0;
        chk(glyph_addr == {codes[0], slot}, "R2 address", glyph_addr, {codes[0], slot});
        @(negedge clk);
        chk(pix_valid == 1'b0, "R3 no pixel before slice", pix_valid, 0);
        for (int i = 0; i < n * 14; i++) begin
            int ci, p;
            ci = i / 14;
            p  = i % 14;
            @(negedge clk);
            if (!pix_valid) gap = 1'b1;
            word = {word[12:0], pix_out};
            line_start = 1'b0;
            chr_valid  = 1'b0;
            if (poke && i == 2) begin      // R10 injection mid-cell
                line_start = 1'b1; raster_line = 4'd0;
                chr_valid = 1'b1; chr_code = 8'h9F;
            end
            if (p == 11 && ci + 1 < n) begin
                chr_valid = 1'b1; chr_code = codes[ci + 1];
            end
            if (p == 12 && ci + 1 < n)
                chk(glyph_addr == {codes[ci + 1], slot}, "R5 chained address",
                    glyph_addr, {codes[ci + 1], slot});
            if (p == 13) begin
                expw = gfun({codes[ci], slot});
                if (ci == cur) expw = expw ^ 14'h00FF;
                chk(word == expw, (ci == cur) ? "R4 cursor cell" : "R3 cell pixels", word, expw);
            end
        end
        chk(!gap, "R5 no gap in pix_valid", gap, 0);
        @(negedge clk);
        chk(pix_valid == 1'b0, "R6 scanline ends", pix_valid, 0);
        m_ln = (m_ln + 1) % 250;
        chk(line_num == 8'(m_ln), "R6 line counter", line_num, m_ln);
        chk(attr_out == exp_attr, "R7 R8 attribute", attr_out, exp_attr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pix_valid == 1'b0, "R1 pix_valid", pix_valid, 0);
        chk(attr_out == 4'h0, "R1 attr", attr_out, 0);
        chk(line_num == 8'd0, "R1 line_num", line_num, 0);
        chk(glyph_addr == 12'd0, "R1 glyph_addr", glyph_addr, 0);

        for (int v = 0; v < NV; v++)
            run_line(VEC[v][39:36], int'(VEC[v][35:32]), int'(VEC[v][31:28]),
                     VEC[v][27:20], VEC[v][19:12], VEC[v][11:4], 1'b0, VEC[v][3:0]);

        // R9: vsync clears screen attribute only
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); vsync = 1'b0;
        chk(attr_out == 4'hA, "R9 row attribute kept", attr_out, 4'hA);
        run_line(4'd1, 15, 1, 8'h41, 8'h00, 8'h00, 1'b0, 4'h0);

        // R10: codes ignored while idle
        held = glyph_addr;
        chr_valid = 1'b1; chr_code = 8'h77;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(pix_valid == 1'b0, "R10 idle code ignored", pix_valid, 0);
        end
        chr_valid = 1'b0;
        @(negedge clk);
        chk(glyph_addr == held, "R10 idle address unchanged", glyph_addr, held);

        // R10: mid-cell marker and scanline start ignored
        run_line(4'd0, 15, 1, 8'h96, 8'h00, 8'h00, 1'b0, 4'h6);
        run_line(4'd0, 15, 1, 8'h41, 8'h00, 8'h00, 1'b1, 4'h6);

        // R6: counter wrap at 250, slot checked on every line
        while (m_ln != 0)
            run_line(4'd1, 15, 1, 8'h30, 8'h00, 8'h00, 1'b0, 4'h6);
        chk(line_num == 8'd0, "R6 wrap to zero", line_num, 0);
        run_line(4'd1, 0, 2, 8'h61, 8'h62, 8'h00, 1'b0, 4'h6);

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(line_num == 8'd0, "R1 line_num after reset", line_num, 0);
        chk(attr_out == 4'h0, "R1 attr after reset", attr_out, 0);
        chk(glyph_addr == 12'd0, "R1 addr after reset", glyph_addr, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule